// File: doc/BRIEF.md
# Polled/Interrupt Character Output Port

This block is a one-byte character output device on a 32-bit bus. Software uses it in one of two ways. It can poll a ready flag in the control register. It can also set an interrupt enable so that a level-1 interrupt request is raised whenever the device can take another byte. A write to the data register hands one byte to a parallel output, which presents it with a single-cycle valid strobe.

After each accepted byte the device reports itself busy for a fixed number of clock cycles, set by a parameter. It then becomes ready again. A data write made while busy is discarded and does not extend the busy period. Bus reads are combinational: the read data follows the address in the same cycle.

Top module: `term_tx`

## Requirements
- R1: After reset, ready reads 1, interrupt enable reads 0, `irq_l1` is 0 and `out_valid` is 0.
- R2: Reading address 0xFFFF0008 (control) returns ready in bit 0 and interrupt enable in bit 1, with bits 31..2 as zero. A write to control loads interrupt enable from write-data bit 1. Write-data bit 0 and bits 31..2 have no effect.
- R3: `irq_l1` is 1 exactly while ready and interrupt enable are both 1.
- R4: A write to address 0xFFFF000C (data) while ready is 1 raises `out_valid` for exactly one cycle, in the cycle after the write edge. `out_byte` then equals write-data bits 7..0, and bits 31..8 are ignored.
- R5: Once a data write has been accepted, ready reads 0 for exactly BUSY_CYCLES cycles and then reads 1.
- R6: A data write while ready is 0 produces no strobe and does not change when ready returns.
- R7: Reads of the data address, and of any address other than control, return zero. Writes to any address other than control and data change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Bus byte address |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| out_byte | output | 8 | Byte being sent |
| out_valid | output | 1 | One-cycle strobe that marks a new byte |
| irq_l1 | output | 1 | Level-1 interrupt request |

## Verification
The device state that matters is the busy counter and the enable flag. Both show at the ports in the very next cycle, because the control read is combinational and `irq_l1` follows them directly. If the counter is loaded wrongly, or is restarted by a dropped write, the point where ready rises moves by at least one cycle. That appears as a mismatch in the first control read taken after the correct return point. A corrupted enable flag shows in the same cycle on both `irq_l1` and control bit 1. A missing or extra strobe is detected in the cycle it occurs.

// File: rtl/term_tx_pkg.sv
package term_tx_pkg;
   localparam int unsigned BUS_W = 32;
   localparam logic [BUS_W-1:0] CTRL_ADDR_DEF = 32'hFFFF_0008;
   localparam logic [BUS_W-1:0] DATA_ADDR_DEF = 32'hFFFF_000C;
   localparam int unsigned RDY_BIT = 0;
   localparam int unsigned IEN_BIT = 1;
   typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_DATA} reg_sel_e;
endpackage

// File: rtl/tx_addr_decode.sv
module tx_addr_decode
   import term_tx_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = CTRL_ADDR_DEF,
   parameter logic [ADDR_W-1:0] DATA_ADDR = DATA_ADDR_DEF
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   if (CTRL_ADDR == DATA_ADDR) begin : g_bad_map
      $error("control and data addresses must differ");
   end
   always_comb begin
      if (addr == CTRL_ADDR)      sel = SEL_CTRL;
      else if (addr == DATA_ADDR) sel = SEL_DATA;
      else                        sel = SEL_NONE;
   end
endmodule

// File: rtl/tx_busy_timer.sv
module tx_busy_timer #(
   parameter int unsigned BUSY_CYCLES = 20,
   localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready
);
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start && ready) cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end
   assign ready = (cnt_q == '0);

   AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready); // R5
   AST_BUSY_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && cnt_q > 1) |=> !ready); // R6
endmodule

// File: rtl/tx_ctrl_reg.sv
module tx_ctrl_reg
   import term_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output logic              ien
);
   if (DATA_W <= IEN_BIT) begin : g_bad_width
      $error("data width too small for enable bit");
   end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ien <= 1'b0;
      else if (wr_ctrl) ien <= wdata[IEN_BIT];
   end
endmodule

// File: rtl/term_tx.sv
module term_tx
   import term_tx_pkg::*;
#(
   parameter int unsigned BUSY_CYCLES = 20,
   parameter logic [31:0] CTRL_ADDR = CTRL_ADDR_DEF,
   parameter logic [31:0] DATA_ADDR = DATA_ADDR_DEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] bus_addr,
   input  logic        bus_we,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [7:0]  out_byte,
   output logic        out_valid,
   output logic        irq_l1
);
   reg_sel_e sel;
   logic ready, ien, wr_data, wr_ctrl;

   tx_addr_decode #(.ADDR_W(32), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR))
      u_dec (.addr(bus_addr), .sel(sel));

   assign wr_data = bus_we && (sel == SEL_DATA);
   assign wr_ctrl = bus_we && (sel == SEL_CTRL);

   tx_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES))
      u_tmr (.clk(clk), .rst_n(rst_n), .start(wr_data), .ready(ready));

   tx_ctrl_reg #(.DATA_W(32))
      u_ctl (.clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .ien(ien));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_byte  <= '0;
      end else begin
         out_valid <= wr_data && ready;
         if (wr_data && ready) out_byte <= bus_wdata[7:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel == SEL_CTRL) begin
         bus_rdata[RDY_BIT] = ready;
         bus_rdata[IEN_BIT] = ien;
      end
   end

   assign irq_l1 = ready && ien;

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R4
   AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !ready); // R5
   AST_NO_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !irq_l1); // R3
   AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !ready) |=> !out_valid); // R6
   AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:2] == 30'd0); // R2
endmodule

// File: tb/term_tx_tb_top.sv
module term_tx_tb_top;
   localparam int B = 6;
   localparam logic [31:0] CA = 32'hFFFF_0008;
   localparam logic [31:0] DA = 32'hFFFF_000C;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic bus_we = 1'b0, out_valid, irq_l1;
   logic [7:0] out_byte;
   int checks = 0, fails = 0;

   int m_cnt = 0;
   bit m_ie = 0, m_val = 0;
   logic [7:0] m_byte = '0;

   always #2 clk = ~clk;

   term_tx #(.BUSY_CYCLES(B)) dut_i (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic [31:0] a, logic we, logic [31:0] d, string tag);
      logic [31:0] er;
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = d;
      #1;
      er = (a == CA) ? {30'd0, m_ie, (m_cnt == 0)} : 32'd0;
      chk(tag, bus_rdata, er);
      chk("R3 irq", {31'd0, irq_l1}, {31'd0, m_ie && (m_cnt == 0)});
      chk("R4 valid", {31'd0, out_valid}, {31'd0, m_val});
      if (m_val) chk("R4 byte", {24'd0, out_byte}, {24'd0, m_byte});
      @(posedge clk);
      if (we && a == CA) m_ie = d[1];
      m_val = 0;
      if (we && a == DA && m_cnt == 0) begin
         m_val = 1; m_byte = d[7:0]; m_cnt = B;
      end else if (m_cnt > 0) m_cnt--;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 valid", {31'd0, out_valid}, 32'd0);
      chk("R1 irq", {31'd0, irq_l1}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      step(CA, 0, 0, "R1 ctrl");
      step(CA, 1, 32'hFFFF_FFFD, "R2 ctrl write");
      step(CA, 0, 0, "R2 ctrl");
      step(CA, 1, 32'hFFFF_FFFF, "R2 ctrl write");
      step(CA, 0, 0, "R2 ien set");
      step(DA, 1, 32'hABCD_EF41, "R7 data read");
      n = 0;
      for (int i = 0; i < 3 * B; i++) begin
         step(CA, 0, 0, "R5 poll");
         if (bus_rdata[0] == 1'b0) n++;
      end
      chk("R5 busy length", n, B);
      step(DA, 1, 32'h0000_0077, "R4 second byte");
      step(DA, 1, 32'h0000_0055, "R6 dropped write");
      n = 1;
      for (int i = 0; i < 3 * B; i++) begin
         step(CA, 0, 0, "R6 poll");
         if (bus_rdata[0] == 1'b0) n++;
      end
      chk("R6 busy unchanged", n, B);
      step(CA, 1, 32'h0000_0001, "R2 clear ien");
      step(CA, 0, 0, "R3 ien off");
      step(32'hFFFF_0010, 1, 32'hFFFF_FFFF, "R7 other write");
      step(32'hFFFF_0004, 0, 0, "R7 other read");
      step(CA, 0, 0, "R7 ctrl unchanged");
      for (int i = 0; i < 40; i++)
         step(DA, 1, 32'h100 * i + i, "R6 back-to-back");
      step(CA, 1, 32'h2, "R2 ien on");
      for (int i = 0; i < 2 * B; i++) step(CA, 0, 0, "R3 irq return");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule